// File: doc/BRIEF.md
# Light-Load Mode Controller for a Buck Channel

This block decides, for one switching-regulator channel, whether the power stage is driven by the fixed-frequency pulse-width modulator or by a pulse-frequency burst sequencer. At light load the channel drops into the burst mode, where this controller drives the high-side (PFET) and low-side (NFET) gate requests directly. When the load rises, or when software forbids the burst mode, it hands the channel back to the modulator.

The inputs are raw comparator flags and the controller synchronizes them. The flags report low-side zero current, a peak current below the mode threshold, a peak current above the burst limit, the output at or above the upper threshold, and the output below the lower and the lowest thresholds. The controller also takes a force-PWM control bit and a one-cycle tick from the modulator clock. Entry into the burst mode needs a qualifying condition that lasts for a set number of ticks. Inside the burst mode, each burst turns the PFET on, then the NFET until zero current, and repeats until the output reaches the upper threshold. The channel then sleeps with both switches off.

States: `ST_PWM` (modulator owns the stage), `ST_PFET_ON`, `ST_DEAD_PN` (gap after the PFET), `ST_NFET_ON`, `ST_DEAD_NP` (gap after the NFET), and `ST_SLEEP`. Transitions:
- enter: `ST_PWM`→`ST_PFET_ON` or →`ST_SLEEP`.
- PFET cut-off: `ST_PFET_ON`→`ST_DEAD_PN`.
- gap end: `ST_DEAD_PN`→`ST_NFET_ON`.
- zero current: `ST_NFET_ON`→`ST_DEAD_NP` or →`ST_SLEEP`.
- re-pulse: `ST_DEAD_NP`→`ST_PFET_ON` or →`ST_SLEEP`.
- wake: `ST_SLEEP`→`ST_PFET_ON`.
- leave: any burst-mode state →`ST_PWM`.

Top module: `pfm_mode_ctrl`

## Requirements
- R1: From `ST_PWM`, with force-PWM low, the controller enters the burst mode once the synchronized low-side zero-current flag or the synchronized peak-below-threshold flag has been true for QUAL_TICKS (default 32) `pwm_tick` pulses. After the 31st tick it must still be in `ST_PWM`. On entry it goes to `ST_SLEEP` if `vout_hi_i` is 1, and to `ST_PFET_ON` otherwise.
- R2: In `ST_PFET_ON`, `pfet_req` is 1 and stays 1 until the synchronized `vout_hi_i` or `peak_lim_i` is 1.
- R3: After the PFET turns off, `nfet_req` is 1 in `ST_NFET_ON` until the synchronized `nfet_zero_i` is 1.
- R4: When zero current is reached, the controller starts another PFET pulse if `vout_hi_i` is 0. If `vout_hi_i` is 1, it enters `ST_SLEEP` with both requests low and `sleep_out` at 1.
- R5: In `ST_SLEEP`, `vout_lo_i`=1 starts a new PFET pulse. With `vout_lo_i`=0 the controller stays asleep.
- R6: While `force_pwm` is 1 the burst mode is never entered. Setting `force_pwm` in any burst-mode state returns the controller to `ST_PWM` on the next clock edge.
- R7: `pfet_req` and `nfet_req` are never 1 together. After either falls, at least one clock passes with both low before the other rises.
- R8: The qualification count clears in any cycle in which neither entry flag is true, so a later entry needs the full QUAL_TICKS ticks again.
- R9: After reset the controller is in `ST_PWM`: `pfm_mode`, `pfet_req`, `nfet_req` and `sleep_out` are all 0, and the count is clear.
- R10: In `ST_PWM`, `pfet_req`, `nfet_req` and `sleep_out` are 0, and `pfm_mode` is 0. In every burst-mode state `pfm_mode` is 1.
- R11: Each comparator flag passes through SYNC_STAGES (default 2) flip-flops. A flag change made between edges is acted on at the third rising edge after it.
- R12: `vout_lo2_i`=1 in any burst-mode state returns the controller to `ST_PWM`, and it takes priority over `vout_lo_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| force_pwm | input | 1 | 1 forbids the burst mode |
| pwm_tick | input | 1 | One-cycle pulse per modulator period |
| nfet_zero_i | input | 1 | Raw flag: low-side current has reached zero |
| peak_low_i | input | 1 | Raw flag: peak PFET current below the mode threshold |
| peak_lim_i | input | 1 | Raw flag: peak current above the burst limit |
| vout_hi_i | input | 1 | Raw flag: output at or above the upper threshold |
| vout_lo_i | input | 1 | Raw flag: output below the lower threshold |
| vout_lo2_i | input | 1 | Raw flag: output below the lowest threshold |
| pfm_mode | output | 1 | 1 while in the burst mode |
| pfet_req | output | 1 | High-side gate request (burst mode) |
| nfet_req | output | 1 | Low-side gate request (burst mode) |
| sleep_out | output | 1 | 1 while both switches rest in sleep |

## Verification
The bench sweeps the tick spacing and checks the entry boundary at 31 and 32 ticks. A counter that is off by one, or that counts clocks instead of ticks, enters one tick early or late. A one-cycle drop of the entry flag must restart the count; a counter that only pauses enters early. The bench walks every burst transition and times each flag through the two-stage synchronizer. It checks that a design without dead-time states shows the PFET and the NFET requested on adjacent clocks, and that a sleep state which ignores the lowest threshold, or tests the lower threshold first, never returns to PWM. It also checks that a forced exit waits for no extra cycle.

// File: rtl/pfm_mode_pkg.sv
`timescale 1ns/1ps
package pfm_mode_pkg;

    typedef enum logic [2:0] {
        ST_PWM     = 3'd0,
        ST_PFET_ON = 3'd1,
        ST_DEAD_PN = 3'd2,
        ST_NFET_ON = 3'd3,
        ST_DEAD_NP = 3'd4,
        ST_SLEEP   = 3'd5
    } mode_state_e;

    // bit positions inside the synchronized flag vector
    localparam int FLG_ZERO = 0;
    localparam int FLG_PKLO = 1;
    localparam int FLG_PLIM = 2;
    localparam int FLG_VHI  = 3;
    localparam int FLG_VLO  = 4;
    localparam int FLG_VLO2 = 5;
    localparam int FLG_NUM  = 6;

endpackage

// File: rtl/pfm_flag_sync.sv
`timescale 1ns/1ps
module pfm_flag_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        if (STAGES <= 1) begin : g_single
            logic [WIDTH-1:0] stage_q;
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= din;
            end
            assign dout = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stage_q;
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[STAGES-2:0], din};
            end
            assign dout = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pfm_entry_qual.sv
`timescale 1ns/1ps
module pfm_entry_qual #(
    parameter int QUAL_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic cond,
    input  logic tick,
    output logic qualified
);

    localparam int CW = $clog2(QUAL_TICKS + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(QUAL_TICKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!arm || !cond) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign qualified = arm && cond && (cnt_q == CNT_MAX);

endmodule

// File: rtl/pfm_burst_fsm.sv
`timescale 1ns/1ps
module pfm_burst_fsm
    import pfm_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic force_pwm,
    input  logic qualified,
    input  logic zero_s,
    input  logic plim_s,
    input  logic vhi_s,
    input  logic vlo_s,
    input  logic vlo2_s,
    output logic in_pwm,
    output logic pfm_mode,
    output logic pfet_req,
    output logic nfet_req,
    output logic sleep_out
);

    mode_state_e state_q;
    mode_state_e state_d;

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (state_q == ST_PWM) begin
            if (!force_pwm && qualified)
                state_d = vhi_s ? ST_SLEEP : ST_PFET_ON;
        end else if (force_pwm || vlo2_s) begin
            state_d = ST_PWM;
        end else begin
            unique case (state_q)
                ST_PFET_ON: if (vhi_s || plim_s) state_d = ST_DEAD_PN;
                ST_DEAD_PN: state_d = ST_NFET_ON;
                ST_NFET_ON: if (zero_s) state_d = vhi_s ? ST_SLEEP : ST_DEAD_NP;
                ST_DEAD_NP: state_d = vhi_s ? ST_SLEEP : ST_PFET_ON;
                ST_SLEEP:   if (vlo_s) state_d = ST_PFET_ON;
                default:    state_d = ST_PWM;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PWM;
        else        state_q <= state_d;
    end

    // outputs decoded from the state
    always_comb begin
        pfm_mode  = 1'b1;
        pfet_req  = 1'b0;
        nfet_req  = 1'b0;
        sleep_out = 1'b0;
        unique case (state_q)
            ST_PWM:     pfm_mode  = 1'b0;
            ST_PFET_ON: pfet_req  = 1'b1;
            ST_NFET_ON: nfet_req  = 1'b1;
            ST_SLEEP:   sleep_out = 1'b1;
            ST_DEAD_PN, ST_DEAD_NP: ;
            default:    pfm_mode  = 1'b0;
        endcase
    end

    assign in_pwm = (state_q == ST_PWM);

endmodule

// File: rtl/pfm_mode_ctrl.sv
`timescale 1ns/1ps
module pfm_mode_ctrl
    import pfm_mode_pkg::*;
#(
    parameter int QUAL_TICKS  = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_pwm,
    input  logic pwm_tick,
    input  logic nfet_zero_i,
    input  logic peak_low_i,
    input  logic peak_lim_i,
    input  logic vout_hi_i,
    input  logic vout_lo_i,
    input  logic vout_lo2_i,
    output logic pfm_mode,
    output logic pfet_req,
    output logic nfet_req,
    output logic sleep_out
);

    logic [FLG_NUM-1:0] flags_raw;
    logic [FLG_NUM-1:0] flags_s;
    logic               in_pwm;
    logic               qualified;

    always_comb begin
        flags_raw           = '0;
        flags_raw[FLG_ZERO] = nfet_zero_i;
        flags_raw[FLG_PKLO] = peak_low_i;
        flags_raw[FLG_PLIM] = peak_lim_i;
        flags_raw[FLG_VHI]  = vout_hi_i;
        flags_raw[FLG_VLO]  = vout_lo_i;
        flags_raw[FLG_VLO2] = vout_lo2_i;
    end

    pfm_flag_sync #(.WIDTH(FLG_NUM), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (flags_raw),
        .dout  (flags_s)
    );

    pfm_entry_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (in_pwm && !force_pwm),
        .cond      (flags_s[FLG_ZERO] || flags_s[FLG_PKLO]),
        .tick      (pwm_tick),
        .qualified (qualified)
    );

    pfm_burst_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_pwm (force_pwm),
        .qualified (qualified),
        .zero_s    (flags_s[FLG_ZERO]),
        .plim_s    (flags_s[FLG_PLIM]),
        .vhi_s     (flags_s[FLG_VHI]),
        .vlo_s     (flags_s[FLG_VLO]),
        .vlo2_s    (flags_s[FLG_VLO2]),
        .in_pwm    (in_pwm),
        .pfm_mode  (pfm_mode),
        .pfet_req  (pfet_req),
        .nfet_req  (nfet_req),
        .sleep_out (sleep_out)
    );

endmodule

// File: rtl/pfm_mode_ctrl_chk.sv
`timescale 1ns/1ps
module pfm_mode_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic force_pwm,
    input logic pfm_mode,
    input logic pfet_req,
    input logic nfet_req,
    input logic sleep_out
);

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(pfet_req && nfet_req));

    a_r7_gap_after_pfet: assert property (@(posedge clk) disable iff (!rst_n)
        pfet_req |=> !nfet_req);

    a_r7_gap_after_nfet: assert property (@(posedge clk) disable iff (!rst_n)
        nfet_req |=> !pfet_req);

    a_r6_force_exit: assert property (@(posedge clk) disable iff (!rst_n)
        force_pwm |=> !pfm_mode);

    a_r4_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_out |-> (pfm_mode && !pfet_req && !nfet_req));

    a_r10_pwm_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pfm_mode |-> (!pfet_req && !nfet_req && !sleep_out));

endmodule

bind pfm_mode_ctrl pfm_mode_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_pwm (force_pwm),
    .pfm_mode  (pfm_mode),
    .pfet_req  (pfet_req),
    .nfet_req  (nfet_req),
    .sleep_out (sleep_out)
);

// File: tb/pfm_mode_ctrl_test.sv
`timescale 1ns/1ps
module pfm_mode_ctrl_test;

    localparam int QT = 32;

    // expected {pfm_mode, pfet_req, nfet_req, sleep_out}
    localparam logic [3:0] E_PWM   = 4'b0000;
    localparam logic [3:0] E_PFET  = 4'b1100;
    localparam logic [3:0] E_DEAD  = 4'b1000;
    localparam logic [3:0] E_NFET  = 4'b1010;
    localparam logic [3:0] E_SLEEP = 4'b1001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic force_pwm = 1'b0, pwm_tick = 1'b0;
    logic nfet_zero_i = 1'b0, peak_low_i = 1'b0, peak_lim_i = 1'b0;
    logic vout_hi_i = 1'b0, vout_lo_i = 1'b0, vout_lo2_i = 1'b0;
    logic pfm_mode, pfet_req, nfet_req, sleep_out;

    int checks = 0;
    int errors = 0;
    int ovl_err = 0;
    bit done = 1'b0;
    logic prev_p = 1'b0, prev_n = 1'b0;

    always #4 clk = ~clk;

    pfm_mode_ctrl #(.QUAL_TICKS(QT), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .force_pwm(force_pwm), .pwm_tick(pwm_tick),
        .nfet_zero_i(nfet_zero_i), .peak_low_i(peak_low_i), .peak_lim_i(peak_lim_i),
        .vout_hi_i(vout_hi_i), .vout_lo_i(vout_lo_i), .vout_lo2_i(vout_lo2_i),
        .pfm_mode(pfm_mode), .pfet_req(pfet_req), .nfet_req(nfet_req),
        .sleep_out(sleep_out)
    );

    // overlap and dead-time monitor (R7)
    always @(negedge clk) begin
        if (rst_n) begin
            if ((pfet_req && nfet_req) || (prev_p && nfet_req) || (prev_n && pfet_req))
                ovl_err++;
        end
        prev_p = pfet_req;
        prev_n = nfet_req;
    end

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {pfm_mode, pfet_req, nfet_req, sleep_out};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) pwm_tick = 1'b1;
            @(negedge clk) pwm_tick = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    initial begin
        clocks(3);
        rst_n = 1'b1;
        clocks(1);
        check("R9 reset state", E_PWM);

        // R6: forced PWM blocks entry
        force_pwm = 1'b1;
        peak_low_i = 1'b1;
        clocks(3);
        ticks(40, 0);
        clocks(2);
        check("R6 forced never enters", E_PWM);
        force_pwm = 1'b0;
        clocks(1);

        // R8: a one-cycle-visible drop restarts the count
        ticks(20, 1);
        peak_low_i = 1'b0;
        clocks(1);
        peak_low_i = 1'b1;
        clocks(4);
        ticks(QT - 1, 0);
        clocks(3);
        check("R8 count cleared, still PWM after 31", E_PWM);
        ticks(1, 0);
        clocks(1);
        check("R1 enter on 32nd tick to PFET", E_PFET);
        peak_low_i = 1'b0;

        // R2: PFET holds, then limit cuts it
        clocks(5);
        check("R2 PFET held", E_PFET);
        peak_lim_i = 1'b1;
        clocks(2);
        check("R11 no reaction after two edges", E_PFET);
        clocks(1);
        check("R7 dead after PFET", E_DEAD);
        clocks(1);
        check("R3 NFET on", E_NFET);
        peak_lim_i = 1'b0;
        clocks(5);
        check("R3 NFET held", E_NFET);

        // R4: zero current with output low -> new pulse
        nfet_zero_i = 1'b1;
        clocks(3);
        check("R7 dead after NFET", E_DEAD);
        clocks(1);
        check("R4 re-pulse", E_PFET);
        nfet_zero_i = 1'b0;
        clocks(4);

        // R4: high threshold reached -> NFET then sleep
        vout_hi_i = 1'b1;
        clocks(3);
        check("R2 high cuts PFET", E_DEAD);
        clocks(1);
        check("R3 NFET after high", E_NFET);
        nfet_zero_i = 1'b1;
        clocks(3);
        check("R4 sleep", E_SLEEP);
        nfet_zero_i = 1'b0;
        vout_hi_i = 1'b0;
        clocks(6);
        check("R5 stays asleep without low", E_SLEEP);

        // R5: low wakes
        vout_lo_i = 1'b1;
        clocks(3);
        check("R5 wake to PFET", E_PFET);
        vout_lo_i = 1'b0;

        // R12: lowest threshold mid-pulse
        vout_lo2_i = 1'b1;
        clocks(3);
        check("R12 low2 in PFET returns PWM", E_PWM);
        vout_lo2_i = 1'b0;
        clocks(4);

        // re-enter via zero-current flag only, to sleep
        nfet_zero_i = 1'b1;
        vout_hi_i = 1'b1;
        clocks(3);
        ticks(QT, 0);
        clocks(1);
        check("R1 enter via zero flag to sleep", E_SLEEP);
        vout_lo_i = 1'b1;
        vout_lo2_i = 1'b1;
        clocks(3);
        check("R12 low2 priority over low in sleep", E_PWM);
        vout_lo_i = 1'b0;
        vout_lo2_i = 1'b0;
        clocks(3);

        // sweep tick spacing: boundary 31/32 and forced exit
        for (int gap = 0; gap < 4; gap++) begin
            ticks(QT - 1, gap);
            clocks(3);
            check("R1 sweep still PWM after 31", E_PWM);
            ticks(1, gap);
            clocks(1);
            check("R1 sweep entered after 32", E_SLEEP);
            @(negedge clk) force_pwm = 1'b1;
            @(negedge clk);
            check("R6 immediate forced exit", E_PWM);
            force_pwm = 1'b0;
        end

        checks++;
        if (ovl_err != 0) begin
            errors++;
            $display("FAIL R7 overlap monitor: violations %0d expected 0", ovl_err);
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule